// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a small load/store processor. It takes two word operands, a separate 5-bit shift count and a 4-bit operation code. It returns a word result and a single overflow indication. There are no registers inside the block. Outputs follow the inputs within the same cycle, and the surrounding pipeline captures them at its own stage boundary. The block has no flow control of its own, so it needs no valid/ready handshake.

One adder serves addition, subtraction and both less-than comparisons. Comparisons are done by subtracting B from A and reading the sign, the carry and the overflow of that difference. The overflow output is a plain signal. Deciding whether it causes a trap is left to the logic outside the block.

Top module: `alu_core`

## Requirements
- R1: Code 0 (signed add) returns A+B modulo 2^32 and raises `ovf` exactly when A and B have the same sign and the sum's bit 31 differs from it.
- R2: Code 2 (signed subtract) returns A-B modulo 2^32 and raises `ovf` exactly when the mathematical difference lies outside -2^31..2^31-1.
- R3: Codes 1 (unsigned add) and 3 (unsigned subtract) return the same wrapped word as codes 0 and 2. For every code other than 0 and 2, `ovf` stays low.
- R4: Code 9 (signed less-than) returns 1 when A < B as two's complement numbers and 0 otherwise. Bits 31:1 are always zero, and the answer is correct even when A-B overflows.
- R5: Code 10 (unsigned less-than) returns 1 when A < B as unsigned magnitudes and 0 otherwise. For example, A=0xFFFFFFFA and B=0x0000FFFA give 1 under code 9 and 0 under code 10.
- R6: Code 6 shifts A left by `shamt` (0..31) and fills with zeros. Bits leaving bit 31 are dropped and `ovf` stays low. A count of 0 returns A unchanged.
- R7: Code 7 shifts A right by `shamt` and fills the vacated upper bits with zeros.
- R8: Code 8 shifts A right by `shamt` and fills the vacated upper bits with copies of A[31].
- R9: Code 4 returns the bitwise AND of A and B. Code 5 returns the bitwise OR.
- R10: Code 11 places B[15:0] in result bits 31:16 and clears bits 15:0. A has no effect on the result.
- R11: Codes 12 to 15 return a zero result with `ovf` low, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, values as listed in the requirements |
| opnd_a | input | 32 | First operand; also the value that gets shifted |
| opnd_b | input | 32 | Second operand; source of the half-word for code 11 |
| shamt | input | 5 | Shift count for codes 6, 7 and 8 |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed add/subtract overflow |

## Verification
The hardest condition to reach is signed less-than when the internal subtraction overflows. There the raw sign of the difference gives the wrong answer, and only the overflow correction saves it. The stimulus drives operand pairs at opposite extremes of the signed range, such as 0x80000000 against 1 and 0x7FFFFFFF against 0x80000000, under both comparison codes. The same pairs also go through the subtract codes, so the result word and `ovf` can be compared against the comparison outcome. The undefined codes are driven with operands that would overflow under code 0, so a zero result with `ovf` low shows they are truly quiet.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int ALU_W   = 32;
  localparam int SHAMT_W = $clog2(ALU_W);
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_SLT  = 4'd9,
    OP_SLTU = 4'd10,
    OP_LUI  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_mode_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf_raw
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff   = b ^ {W{sub}};
  assign wide    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum     = wide[W-1:0];
  assign carry   = wide[W];
  assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    if (!sub && b == '0)
      assert_add_zero_R1: assert (sum == a && !ovf_raw)
        else $error("adding zero changed the operand or flagged overflow");
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  shift_mode_e    mode,
  output logic [W-1:0]   dout
);
  logic              fill;
  logic [SHW:0][W-1:0] stg;

  assign fill   = (mode == SH_RARI) ? din[W-1] : 1'b0;
  assign stg[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    assign moved = (mode == SH_LEFT) ? {stg[k][W-1-S:0], {S{1'b0}}}
                                     : {{S{fill}}, stg[k][W-1:S]};
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[SHW];

  always_comb begin
    if (amt == '0)
      assert_shift_zero_amt_R6: assert (dout == din)
        else $error("zero shift count altered the operand");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] upper_o
);
  localparam int HALF = W / 2;

  assign and_o   = a & b;
  assign or_o    = a | b;
  assign upper_o = {b[HALF-1:0], {HALF{1'b0}}};
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W   = ALU_W,
  parameter int SHW = $clog2(W)
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [SHW-1:0]  shamt,
  output logic [W-1:0]    result,
  output logic            ovf
);
  localparam int HALF = W / 2;

  alu_op_e     op;
  logic        do_sub;
  logic [W-1:0] sum;
  logic        carry;
  logic        ovf_raw;
  shift_mode_e smode;
  logic [W-1:0] sh_out;
  logic [W-1:0] and_v, or_v, upper_v;
  logic        lt_s, lt_u;

  assign op = alu_op_e'(op_sel);
  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) ||
                  (op == OP_SLT) || (op == OP_SLTU);

  always_comb begin
    case (op)
      OP_SRL:  smode = SH_RLOG;
      OP_SRA:  smode = SH_RARI;
      default: smode = SH_LEFT;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(do_sub),
    .sum(sum), .carry(carry), .ovf_raw(ovf_raw)
  );

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .din(opnd_a), .amt(shamt), .mode(smode), .dout(sh_out)
  );

  alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b),
    .and_o(and_v), .or_o(or_v), .upper_o(upper_v)
  );

  assign lt_s = sum[W-1] ^ ovf_raw;
  assign lt_u = ~carry;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        result = sum;
        ovf    = ovf_raw;
      end
      OP_ADDU, OP_SUBU: result = sum;
      OP_AND:  result = and_v;
      OP_OR:   result = or_v;
      OP_SLL, OP_SRL, OP_SRA: result = sh_out;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(W-1){1'b0}}, lt_u};
      OP_LUI:  result = upper_v;
      default: begin
        result = '0;
        ovf    = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (op_sel != OP_ADD && op_sel != OP_SUB)
      assert_unsigned_quiet_R3: assert (!ovf)
        else $error("overflow raised by a non-signed-arith code");
    if (op_sel == OP_SLT || op_sel == OP_SLTU)
      assert_slt_bool_R4: assert (result[W-1:1] == '0)
        else $error("comparison produced upper bits");
    if (op_sel == OP_LUI)
      assert_lui_low_clear_R10: assert (result[HALF-1:0] == '0)
        else $error("upper placement left low half nonzero");
    if (op_sel > OP_LUI)
      assert_undef_zero_R11: assert (result == '0 && !ovf)
        else $error("undefined code produced output");
  end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_core u0 (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .result(result), .ovf(ovf)
  );

  task automatic drive(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s);
    @(posedge clk);
    #2;
    op_sel = op; opnd_a = a; opnd_b = b; shamt = s;
    #5;
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic eo);
    n_chk++;
    if (result !== er || ovf !== eo) begin
      n_bad++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               req, result, ovf, er, eo);
    end
  endtask

  task automatic t_idle();
    #7;
    check("R1 idle", 32'h0, 1'b0);
  endtask

  task automatic t_signed_add();
    drive(4'd0, 32'h7FFFFFFF, 32'h1, 0);        check("R1", 32'h80000000, 1'b1);
    drive(4'd0, 32'hFFFFFFCE, 32'h64, 0);       check("R1", 32'h00000032, 1'b0);
    drive(4'd0, 32'h80000000, 32'h80000000, 0); check("R1", 32'h00000000, 1'b1);
  endtask

  task automatic t_signed_sub();
    drive(4'd2, 32'h80000000, 32'h1, 0);        check("R2", 32'h7FFFFFFF, 1'b1);
    drive(4'd2, 32'h5, 32'h7, 0);               check("R2", 32'hFFFFFFFE, 1'b0);
    drive(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 0); check("R2", 32'h80000000, 1'b1);
  endtask

  task automatic t_unsigned();
    drive(4'd1, 32'h7FFFFFFF, 32'h1, 0);        check("R3", 32'h80000000, 1'b0);
    drive(4'd3, 32'h0, 32'h1, 0);               check("R3", 32'hFFFFFFFF, 1'b0);
    drive(4'd3, 32'h80000000, 32'h1, 0);        check("R3", 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_compare();
    drive(4'd9,  32'hFFFFFFFA, 32'h0000FFFA, 0); check("R4", 32'h1, 1'b0);
    drive(4'd10, 32'hFFFFFFFA, 32'h0000FFFA, 0); check("R5", 32'h0, 1'b0);
    drive(4'd9,  32'h80000000, 32'h1, 0);        check("R4 ovf", 32'h1, 1'b0);
    drive(4'd10, 32'h80000000, 32'h1, 0);        check("R5", 32'h0, 1'b0);
    drive(4'd9,  32'h7FFFFFFF, 32'h80000000, 0); check("R4 ovf", 32'h0, 1'b0);
    drive(4'd10, 32'h7FFFFFFF, 32'h80000000, 0); check("R5", 32'h1, 1'b0);
    drive(4'd9,  32'h12, 32'h12, 0);             check("R4 equal", 32'h0, 1'b0);
  endtask

  task automatic t_shifts();
    drive(4'd6, 32'h12345678, 32'h0, 8);  check("R6", 32'h34567800, 1'b0);
    drive(4'd6, 32'h80000001, 32'h0, 1);  check("R6", 32'h00000002, 1'b0);
    drive(4'd6, 32'hDEADBEEF, 32'h0, 0);  check("R6 zero", 32'hDEADBEEF, 1'b0);
    drive(4'd7, 32'h92345678, 32'h0, 8);  check("R7", 32'h00923456, 1'b0);
    drive(4'd7, 32'h80000000, 32'h0, 31); check("R7", 32'h00000001, 1'b0);
    drive(4'd8, 32'h92345678, 32'h0, 8);  check("R8", 32'hFF923456, 1'b0);
    drive(4'd8, 32'h12345678, 32'h0, 8);  check("R8", 32'h00123456, 1'b0);
    drive(4'd8, 32'h80000000, 32'h0, 31); check("R8", 32'hFFFFFFFF, 1'b0);
  endtask

  task automatic t_logic();
    drive(4'd4, 32'hB6A43D9A, 32'h00000FFF, 0); check("R9 and", 32'h00000D9A, 1'b0);
    drive(4'd5, 32'h12345678, 32'h0000FFFF, 0); check("R9 or", 32'h1234FFFF, 1'b0);
  endtask

  task automatic t_upper();
    drive(4'd11, 32'hFFFFFFFF, 32'hABCD1234, 0); check("R10", 32'h12340000, 1'b0);
    drive(4'd11, 32'h0, 32'h0000BEEF, 0);        check("R10", 32'hBEEF0000, 1'b0);
  endtask

  task automatic t_undefined();
    for (int c = 12; c < 16; c++) begin
      drive(4'(c), 32'h7FFFFFFF, 32'h1, 5);
      check("R11", 32'h0, 1'b0);
    end
  endtask

  initial begin
    t_idle();
    t_signed_add();
    t_signed_sub();
    t_unsigned();
    t_compare();
    t_shifts();
    t_logic();
    t_upper();
    t_undefined();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: result=%h ovf=%b expected completion", result, ovf);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule